// File: doc/BRIEF.md
# Prescaled Real-Time Timebase

This block is a slow-clock timebase built from two counters. A 15-bit fine counter advances once per input clock. A 32-bit coarse counter advances on a tick. The tick comes from one of two sources. In divider mode it fires every 2^n clocks, where n is a 4-bit divide code. In match mode it fires when the fine counter equals the channel-0 compare value.

Each counter can also be made to wrap early. The fine counter can wrap at the channel-0 compare value and the coarse counter at the channel-1 compare value. Software can load either counter directly. A small run controller has two named states: STOPPED and COUNTING. The transitions are:
- start (without stop) moves STOPPED to COUNTING.
- stop moves COUNTING to STOPPED.
- start and stop together always leave the controller in STOPPED.

Counting only happens while the enable input is high and the controller is in COUNTING. A packed view puts both counters into one 32-bit word for a single read. One-cycle pulses mark every coarse increment and every coarse wrap.

Top module: `rtc_timebase`

## Requirements
- R1: After reset both counters read zero, the run status is low, and both flag pulses are low.
- R2: A start command alone makes the run status high from the next cycle. A stop command makes it low from the next cycle, including when start is asserted in the same cycle.
- R3: While enable is high and the run status is high, the fine counter increases by one each clock and wraps from 0x7FFF to 0. Otherwise it holds its value.
- R4: In divider mode (mode select = 0) with divide code n, a coarse tick occurs in an active cycle whose fine count has its low n bits all ones. With n = 0, a tick occurs in every active cycle, giving one coarse step per 2^n clocks.
- R5: In match mode (mode select = 1), a coarse tick occurs in an active cycle whose fine count equals the channel-0 compare value.
- R6: With fine-top enabled, an active cycle that starts with the fine count equal to the channel-0 compare value loads 0 instead of incrementing.
- R7: With coarse-top enabled, a tick that starts with the coarse count equal to the channel-1 compare value loads 0 instead of incrementing.
- R8: The wrap pulse is high for one cycle, together with the new count, whenever a coarse increment wraps. This covers both the natural wrap from all ones and the coarse-top wrap.
- R9: The tick pulse is high for one cycle, together with the new count, after every coarse increment. A write to the coarse counter in the tick cycle suppresses both the increment and the pulse.
- R10: A load strobe on either counter sets that counter to the load data at the next edge. The load takes priority over that cycle's increment or wrap, and works whether or not the block is counting.
- R11: The packed output carries the fine counter in bits 14:0 and coarse counter bits 16:0 in bits 31:15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable; counting stops when low |
| start_cmd | input | 1 | Start command strobe |
| stop_cmd | input | 1 | Stop command strobe (wins over start) |
| tick_sel | input | 1 | 0 = divider ticks, 1 = channel-0 match ticks |
| div_code | input | 4 | Divide code n, tick every 2^n clocks |
| fine_top_en | input | 1 | Fine counter wraps at channel-0 compare value |
| coarse_top_en | input | 1 | Coarse counter wraps at channel-1 compare value |
| cmp0_val | input | 15 | Channel-0 compare value |
| cmp1_val | input | 32 | Channel-1 compare value |
| fine_ld | input | 1 | Fine counter load strobe |
| fine_ld_data | input | 15 | Fine counter load data |
| coarse_ld | input | 1 | Coarse counter load strobe |
| coarse_ld_data | input | 32 | Coarse counter load data |
| running | output | 1 | Run status (controller in COUNTING) |
| fine_cnt | output | 15 | Fine counter |
| coarse_cnt | output | 32 | Coarse counter |
| packed_cnt | output | 32 | Packed fine and coarse count |
| tick_pulse | output | 1 | Coarse increment pulse |
| wrap_pulse | output | 1 | Coarse wrap pulse |

## Verification
The bench builds the block with its default widths: a 15-bit fine counter, a 32-bit coarse counter and a 4-bit divide code. The random phase keeps divide codes low and compare values small, so divider ticks, match ticks and both early wraps occur often within a few thousand cycles. Loads close to all ones bring the natural 32-bit wrap within a handful of ticks. One directed run uses divide code 15, which reaches the full 32768-clock tick period and the 0x7FFF-to-0 wrap of the fine counter.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    typedef enum logic {
        ST_STOPPED  = 1'b0,
        ST_COUNTING = 1'b1
    } run_state_e;
endpackage

// File: rtl/rtc_run_fsm.sv
module rtc_run_fsm
    import rtc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_cmd,
    input  logic stop_cmd,
    output logic running
);
    run_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOPPED:  if (start_cmd && !stop_cmd) state_d = ST_COUNTING;
            ST_COUNTING: if (stop_cmd)               state_d = ST_STOPPED;
            default:     state_d = ST_STOPPED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_STOPPED;
        else        state_q <= state_d;
    end

    always_comb begin
        running = (state_q == ST_COUNTING);
    end

    AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        stop_cmd |=> !running); // R2
    AST_START_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        (start_cmd && !stop_cmd) |=> running); // R2
endmodule

// File: rtl/rtc_fine_counter.sv
module rtc_fine_counter #(
    parameter int FINE_W = 15,
    parameter int DIV_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              tick_sel,
    input  logic [DIV_W-1:0]  div_code,
    input  logic              top_en,
    input  logic [FINE_W-1:0] cmp0_val,
    input  logic              ld,
    input  logic [FINE_W-1:0] ld_data,
    output logic [FINE_W-1:0] cnt,
    output logic              tick
);
    logic [FINE_W-1:0] div_mask;
    logic              at_cmp0;
    logic              div_hit;

    // mask bit i is set when i is below the divide code
    for (genvar i = 0; i < FINE_W; i++) begin : g_mask
        assign div_mask[i] = ((DIV_W+1)'(i) < {1'b0, div_code});
    end

    assign at_cmp0 = (cnt == cmp0_val);
    assign div_hit = ((cnt & div_mask) == div_mask);

    always_comb begin
        tick = active && (tick_sel ? at_cmp0 : div_hit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 cnt <= '0;
        else if (ld)                cnt <= ld_data;
        else if (active) begin
            if (top_en && at_cmp0)  cnt <= '0;
            else                    cnt <= cnt + 1'b1;
        end
    end

    AST_FINE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !ld) |=> $stable(cnt)); // R3
    AST_FINE_TOP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !ld && top_en && at_cmp0) |=> (cnt == '0)); // R6
    AST_FINE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> (cnt == $past(ld_data))); // R10
endmodule

// File: rtl/rtc_coarse_counter.sv
module rtc_coarse_counter #(
    parameter int COARSE_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                top_en,
    input  logic [COARSE_W-1:0] cmp1_val,
    input  logic                ld,
    input  logic [COARSE_W-1:0] ld_data,
    output logic [COARSE_W-1:0] cnt,
    output logic                tick_pulse,
    output logic                wrap_pulse
);
    logic inc;
    logic top_hit;
    logic nat_hit;

    assign inc     = tick && !ld;
    assign top_hit = top_en && (cnt == cmp1_val);
    assign nat_hit = (cnt == '1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt        <= '0;
            tick_pulse <= 1'b0;
            wrap_pulse <= 1'b0;
        end else begin
            tick_pulse <= inc;
            wrap_pulse <= inc && (top_hit || nat_hit);
            if (ld)           cnt <= ld_data;
            else if (inc) begin
                if (top_hit)  cnt <= '0;
                else          cnt <= cnt + 1'b1;
            end
        end
    end

    AST_WRAP_GIVES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_pulse |-> (cnt == '0)); // R8
    AST_WRAP_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_pulse |-> tick_pulse); // R9
    AST_COARSE_TOP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !ld && top_en && cnt == cmp1_val) |=> (cnt == '0)); // R7
    AST_COARSE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> (cnt == $past(ld_data) && !tick_pulse)); // R10
endmodule

// File: rtl/rtc_timebase.sv
module rtc_timebase #(
    parameter int FINE_W   = 15,
    parameter int COARSE_W = 32,
    parameter int DIV_W    = 4,
    parameter int PACK_W   = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic                start_cmd,
    input  logic                stop_cmd,
    input  logic                tick_sel,
    input  logic [DIV_W-1:0]    div_code,
    input  logic                fine_top_en,
    input  logic                coarse_top_en,
    input  logic [FINE_W-1:0]   cmp0_val,
    input  logic [COARSE_W-1:0] cmp1_val,
    input  logic                fine_ld,
    input  logic [FINE_W-1:0]   fine_ld_data,
    input  logic                coarse_ld,
    input  logic [COARSE_W-1:0] coarse_ld_data,
    output logic                running,
    output logic [FINE_W-1:0]   fine_cnt,
    output logic [COARSE_W-1:0] coarse_cnt,
    output logic [PACK_W-1:0]   packed_cnt,
    output logic                tick_pulse,
    output logic                wrap_pulse
);
    localparam int HI_W = PACK_W - FINE_W;

    logic active;
    logic tick;

    rtc_run_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_cmd (start_cmd),
        .stop_cmd  (stop_cmd),
        .running   (running)
    );

    assign active = enable && running;

    rtc_fine_counter #(.FINE_W(FINE_W), .DIV_W(DIV_W)) u_fine (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (active),
        .tick_sel (tick_sel),
        .div_code (div_code),
        .top_en   (fine_top_en),
        .cmp0_val (cmp0_val),
        .ld       (fine_ld),
        .ld_data  (fine_ld_data),
        .cnt      (fine_cnt),
        .tick     (tick)
    );

    rtc_coarse_counter #(.COARSE_W(COARSE_W)) u_coarse (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .top_en     (coarse_top_en),
        .cmp1_val   (cmp1_val),
        .ld         (coarse_ld),
        .ld_data    (coarse_ld_data),
        .cnt        (coarse_cnt),
        .tick_pulse (tick_pulse),
        .wrap_pulse (wrap_pulse)
    );

    assign packed_cnt = {coarse_cnt[HI_W-1:0], fine_cnt};

    AST_TICK_ONLY_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        tick_pulse |-> $past(active)); // R4
endmodule

// File: tb/rtc_timebase_test.sv
module rtc_timebase_test;
    localparam int FINE_W = 15, COARSE_W = 32, DIV_W = 4, PACK_W = 32;

    logic clk = 1'b0, rst_n = 1'b0;
    logic enable = 0, start_cmd = 0, stop_cmd = 0, tick_sel = 0;
    logic [DIV_W-1:0] div_code = '0;
    logic fine_top_en = 0, coarse_top_en = 0, fine_ld = 0, coarse_ld = 0;
    logic [FINE_W-1:0] cmp0_val = '0, fine_ld_data = '0;
    logic [COARSE_W-1:0] cmp1_val = '0, coarse_ld_data = '0;
    logic running, tick_pulse, wrap_pulse;
    logic [FINE_W-1:0] fine_cnt;
    logic [COARSE_W-1:0] coarse_cnt;
    logic [PACK_W-1:0] packed_cnt;

    int checks = 0, fails = 0;
    bit finished = 0;
    string phase = "R1";

    logic [FINE_W-1:0] m_fine = '0;
    logic [COARSE_W-1:0] m_coarse = '0;
    logic m_run = 0, m_tick = 0, m_wrap = 0;

    always #5 clk = ~clk;

    rtc_timebase #(.FINE_W(FINE_W), .COARSE_W(COARSE_W), .DIV_W(DIV_W), .PACK_W(PACK_W)) uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .start_cmd(start_cmd), .stop_cmd(stop_cmd),
        .tick_sel(tick_sel), .div_code(div_code), .fine_top_en(fine_top_en),
        .coarse_top_en(coarse_top_en), .cmp0_val(cmp0_val), .cmp1_val(cmp1_val),
        .fine_ld(fine_ld), .fine_ld_data(fine_ld_data), .coarse_ld(coarse_ld),
        .coarse_ld_data(coarse_ld_data), .running(running), .fine_cnt(fine_cnt),
        .coarse_cnt(coarse_cnt), .packed_cnt(packed_cnt), .tick_pulse(tick_pulse),
        .wrap_pulse(wrap_pulse));

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s (phase %s): got %h expected %h", req, phase, got, exp);
        end
    endtask

    task automatic check_all();
        chk("R2 run status", 32'(running), 32'(m_run));
        chk("R3 fine count", 32'(fine_cnt), 32'(m_fine));
        chk("R4 coarse count", coarse_cnt, m_coarse);
        chk("R9 tick pulse", 32'(tick_pulse), 32'(m_tick));
        chk("R8 wrap pulse", 32'(wrap_pulse), 32'(m_wrap));
        chk("R11 packed", packed_cnt, {m_coarse[16:0], m_fine});
    endtask

    // one clock: compute expected next state from current inputs, then compare
    task automatic step();
        logic act, cond, tk, inc, topw;
        logic [FINE_W-1:0] mask, nf;
        logic [COARSE_W-1:0] nc;
        logic nr;
        act  = enable && m_run;
        mask = FINE_W'((32'd1 << div_code) - 1);
        cond = tick_sel ? (m_fine == cmp0_val) : ((m_fine & mask) == mask);
        tk   = act && cond;
        if (fine_ld) nf = fine_ld_data;
        else if (act) nf = (fine_top_en && m_fine == cmp0_val) ? '0 : m_fine + 1'b1;
        else nf = m_fine;
        inc  = tk && !coarse_ld;
        topw = coarse_top_en && (m_coarse == cmp1_val);
        if (coarse_ld) nc = coarse_ld_data;
        else if (inc) nc = topw ? '0 : m_coarse + 1'b1;
        else nc = m_coarse;
        nr = stop_cmd ? 1'b0 : (start_cmd ? 1'b1 : m_run);
        @(posedge clk);
        #1;
        m_fine = nf; m_coarse = nc; m_run = nr; m_tick = inc;
        m_wrap = inc && (topw || m_coarse == '1 && !topw ? 1'b1 : topw);
        m_wrap = inc && (topw || nc == '0 && !topw);
        check_all();
    endtask

    task automatic steps(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic cmd(logic s, logic p);
        start_cmd = s; stop_cmd = p; step(); start_cmd = 0; stop_cmd = 0;
    endtask

    initial begin
        #1500000;
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog expired in phase %s", phase);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd24601));
        repeat (3) @(posedge clk);
        #1;
        check_all();                       // R1 reset state
        rst_n = 1'b1;
        steps(2);

        phase = "R2"; enable = 1;
        cmd(1, 0); chk("R2 start", 32'(running), 32'd1);
        steps(3);
        cmd(0, 1); chk("R2 stop", 32'(running), 32'd0);
        cmd(1, 1); chk("R2 both stop", 32'(running), 32'd0);
        steps(3);

        phase = "R3"; cmd(1, 0); steps(5);
        enable = 0; steps(5); enable = 1; steps(3);

        phase = "R4"; div_code = 4'd2; steps(20);
        div_code = 4'd0; steps(6);

        phase = "R5"; tick_sel = 1; cmp0_val = 15'd5;
        fine_ld = 1; fine_ld_data = '0; step(); fine_ld = 0; steps(40);

        phase = "R6"; fine_top_en = 1; cmp0_val = 15'd9; steps(40);
        tick_sel = 0; steps(20); fine_top_en = 0;

        phase = "R7"; div_code = 0; coarse_top_en = 1; cmp1_val = 32'd3;
        coarse_ld = 1; coarse_ld_data = '0; step(); coarse_ld = 0; steps(12);
        chk("R7 bounded", 32'(coarse_cnt <= 32'd3), 32'd1);
        coarse_top_en = 0;

        phase = "R8"; coarse_ld = 1; coarse_ld_data = 32'hFFFF_FFFE; step(); coarse_ld = 0;
        step(); step();
        chk("R8 natural wrap", coarse_cnt, 32'd0);
        steps(4);

        phase = "R10"; coarse_ld = 1; coarse_ld_data = 32'h1234_5678;
        fine_ld = 1; fine_ld_data = 15'h7FF0; step();
        chk("R10 coarse load", coarse_cnt, 32'h1234_5678);
        chk("R10 fine load", 32'(fine_cnt), 32'h7FF0);
        chk("R9 no tick on load", 32'(tick_pulse), 32'd0);
        coarse_ld = 0; fine_ld = 0; steps(30);

        phase = "R4"; div_code = 4'd15; fine_ld = 1; fine_ld_data = '0; step(); fine_ld = 0;
        steps(33000);

        phase = "RND";
        for (int i = 0; i < 4000; i++) begin
            enable        = ($urandom % 10) != 0;
            start_cmd     = ($urandom % 20) == 0;
            stop_cmd      = ($urandom % 40) == 0;
            if ($urandom % 50 == 0) tick_sel = $urandom;
            if ($urandom % 50 == 0) div_code = DIV_W'($urandom % 4);
            if ($urandom % 50 == 0) fine_top_en = $urandom;
            if ($urandom % 50 == 0) coarse_top_en = $urandom;
            if ($urandom % 60 == 0) cmp0_val = FINE_W'($urandom % 16);
            if ($urandom % 60 == 0) cmp1_val = $urandom % 8;
            fine_ld        = ($urandom % 80) == 0;
            fine_ld_data   = FINE_W'($urandom % 20);
            coarse_ld      = ($urandom % 80) == 0;
            coarse_ld_data = ($urandom % 2) ? 32'hFFFF_FFFC + ($urandom % 4) : $urandom % 6;
            step();
        end
        start_cmd = 0; stop_cmd = 0; fine_ld = 0; coarse_ld = 0;

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule